// File: doc/BRIEF.md
# Framebuffer Display Scan Controller

This block scans a linear frame buffer in memory and drives a 640x480 flat panel or analogue monitor. It runs the horizontal and vertical raster counters and issues one word read for each visible pixel. It splits each returned 32-bit word into 8-bit red, green and blue outputs that line up with the sync and data-enable outputs. Memory is reached through a plain request/response port. A request is a one-cycle pulse with a word address, and the response (a valid strobe and a data word) arrives a fixed `RD_LAT` cycles later.

Software sees two 32-bit registers through a byte-addressed write/read port: a frame-base register and a control register. The control register holds a display-enable bit and a half-turn (180-degree) view bit. Writes land in shadow copies. The display adopts them only when vertical blanking begins, so every frame is drawn with one setting. Each row of the buffer occupies 1024 words, of which only the first 640 are read. The frame base is kept to 2 MiB granularity.

Top module: `fb_scan_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, no memory request is issued, both syncs are high (inactive), data enable is low, the colour outputs are zero and the register read data is zero. After reset the display is disabled.
- R2: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks (800 by default). hsync_n goes low H_FP clocks after data enable falls and stays low for H_SYNC clocks.
- R3: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines (525 by default). vsync_n goes low V_FP whole lines plus the horizontal blanking time after the last visible pixel, and stays low for V_SYNC lines.
- R4: In normal order, with the display enabled, pixel (x, y) is requested at word address {base[31:21], y, x}, meaning base + y*1024 + x in words, in raster order. Only visible pixels are requested, and consecutive requests within a line step by +1.
- R5: With control bit 1 set, pixel (x, y) is requested at word address base + (V_ACTIVE-1-y)*1024 + (H_ACTIVE-1-x). Consecutive requests within a line step by -1.
- R6: A visible pixel appears at the outputs RD_LAT+2 clocks after its raster position, together with its syncs and data enable, with red = word[23:16], green = word[15:8] and blue = word[7:0]. Bits 31:24 are ignored. The colour outputs are zero whenever data enable is low.
- R7: With control bit 0 clear, the syncs and data enable keep their timing, the colour outputs stay zero and no memory request is issued.
- R8: A register write takes effect only at the first cycle of the next vertical blanking interval. Pixels of the frame in progress keep the previous base and control setting.
- R9: The register index is byte address bit 2: byte offset 0 selects the base register and byte offset 4 selects the control register. Address bits 1:0 are ignored. The base register keeps bits 31:21 of the written value, and a read returns those bits with bits 20:0 zero, one cycle after the address is presented.
- R10: A read of the control register returns the written bit 0 (enable) and bit 1 (rotate), with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for reg_addr |
| mem_req | output | 1 | Pixel word read request |
| mem_addr | output | DATA_W-2 | Word address of the request |
| mem_rvalid | input | 1 | Read response valid, RD_LAT cycles after the request |
| mem_rdata | input | DATA_W | Read response word |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Visible-area data enable |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |

## Verification
The hardest case to reach is a register write that lands while a frame is still being drawn. Pixels after the write must follow the old setting, and the first pixel of the following frame must follow the new one. The stimulus waits for data enable to rise in a frame and then writes a new base and control setting in the first visible row. It then queues expectations for the next frame only after vsync falls, so any early or late adoption shows up as address and colour miscompares. The bench shrinks the raster through parameters so that several frames fit in the run, and walks through normal, half-turn, disabled and re-enabled settings.

// File: rtl/fb_pkg.sv
package fb_pkg;
  // control register bit positions (software depends on them)
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_ROT_BIT = 1;
  // byte address bit that selects the register
  localparam int REG_IDX_BIT  = 2;

  typedef struct packed {
    logic rot;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/fb_regs.sv
module fb_regs
  import fb_pkg::*;
#(
  parameter int REG_AW = 3,
  parameter int DATA_W = 32,
  parameter int BASE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              apply,
  output logic [DATA_W-1:0] rdata,
  output logic [BASE_W-1:0] act_base,
  output ctrl_t             act_ctrl
);
  localparam int LOW_W = DATA_W - BASE_W;

  logic [BASE_W-1:0] sh_base;
  ctrl_t             sh_ctrl;
  logic              sel_ctrl;
  logic              unused_regs;

  assign sel_ctrl    = addr[REG_IDX_BIT];
  assign unused_regs = ^{addr, wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_base  <= '0;
      sh_ctrl  <= '0;
      act_base <= '0;
      act_ctrl <= '0;
      rdata    <= '0;
    end else begin
      if (wr) begin
        if (sel_ctrl) begin
          sh_ctrl.en  <= wdata[CTRL_EN_BIT];
          sh_ctrl.rot <= wdata[CTRL_ROT_BIT];
        end else begin
          sh_base <= wdata[DATA_W-1 -: BASE_W];
        end
      end
      if (apply) begin
        act_base <= sh_base;
        act_ctrl <= sh_ctrl;
      end
      if (sel_ctrl) rdata <= {{(DATA_W-2){1'b0}}, sh_ctrl.rot, sh_ctrl.en};
      else          rdata <= {sh_base, {LOW_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fb_timing.sv
module fb_timing #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int H_W     = $clog2(H_TOTAL),
  localparam int V_W     = $clog2(V_TOTAL)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [H_W-1:0] h_cnt,
  output logic [V_W-1:0] v_cnt,
  output logic           vis,
  output logic           hs,
  output logic           vs,
  output logic           frame_apply
);
  localparam logic [H_W-1:0] H_LAST   = H_W'(H_TOTAL - 1);
  localparam logic [V_W-1:0] V_LAST   = V_W'(V_TOTAL - 1);
  localparam logic [H_W-1:0] HS_START = H_W'(H_ACTIVE + H_FP);
  localparam logic [H_W-1:0] HS_END   = H_W'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [V_W-1:0] VS_START = V_W'(V_ACTIVE + V_FP);
  localparam logic [V_W-1:0] VS_END   = V_W'(V_ACTIVE + V_FP + V_SYNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (h_cnt == H_LAST) begin
      h_cnt <= '0;
      v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
    end else begin
      h_cnt <= h_cnt + 1'b1;
    end
  end

  assign vis         = (h_cnt < H_W'(H_ACTIVE)) && (v_cnt < V_W'(V_ACTIVE));
  assign hs          = (h_cnt >= HS_START) && (h_cnt < HS_END);
  assign vs          = (v_cnt >= VS_START) && (v_cnt < VS_END);
  assign frame_apply = (v_cnt == V_W'(V_ACTIVE)) && (h_cnt == '0);
endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
  import fb_pkg::*;
#(
  parameter int H_ACTIVE    = 640,
  parameter int V_ACTIVE    = 480,
  parameter int H_W         = 10,
  parameter int V_W         = 10,
  parameter int STRIDE_LOG2 = 10,
  parameter int BASE_W      = 11,
  parameter int WADDR_W     = 30,
  localparam int ROW_W      = WADDR_W - BASE_W - STRIDE_LOG2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [H_W-1:0]     h_cnt,
  input  logic [V_W-1:0]     v_cnt,
  input  logic               vis,
  input  logic [BASE_W-1:0]  base,
  input  ctrl_t              ctrl,
  output logic               mem_req,
  output logic [WADDR_W-1:0] mem_addr
);
  logic [STRIDE_LOG2-1:0] col_fwd, col;
  logic [ROW_W-1:0]       row_fwd, row;

  assign col_fwd = STRIDE_LOG2'(h_cnt);
  assign row_fwd = ROW_W'(v_cnt);

  // scan direction variant: the half-turn view mirrors both axes
  always_comb begin
    if (ctrl.rot) begin
      col = STRIDE_LOG2'(H_ACTIVE - 1) - col_fwd;
      row = ROW_W'(V_ACTIVE - 1) - row_fwd;
    end else begin
      col = col_fwd;
      row = row_fwd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_req  <= vis && ctrl.en;
      mem_addr <= {base, row, col};
    end
  end
endmodule

// File: rtl/fb_pixel_out.sv
module fb_pixel_out #(
  parameter int RD_LAT = 2,
  parameter int DATA_W = 32,
  localparam int DLY   = RD_LAT + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vis,
  input  logic              en,
  input  logic              hs,
  input  logic              vs,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              de,
  output logic [7:0]        red,
  output logic [7:0]        green,
  output logic [7:0]        blue
);
  // stage bits: 3 visible, 2 visible and enabled, 1 hsync, 0 vsync
  logic [3:0] stg [DLY];
  logic       unused_px;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= {vis, vis & en, hs, vs};
  end

  for (genvar k = 1; k < DLY; k++) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '0;
      else     stg[k] <= stg[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      red   <= '0;
      green <= '0;
      blue  <= '0;
    end else if (rvalid && stg[RD_LAT][2]) begin
      red   <= rdata[23:16];
      green <= rdata[15:8];
      blue  <= rdata[7:0];
    end else begin
      red   <= '0;
      green <= '0;
      blue  <= '0;
    end
  end

  assign de        = stg[DLY-1][3];
  assign hsync_n   = ~stg[DLY-1][1];
  assign vsync_n   = ~stg[DLY-1][0];
  assign unused_px = ^{stg[DLY-1][2], rdata};
endmodule

// File: rtl/fb_scan_ctrl.sv
module fb_scan_ctrl
  import fb_pkg::*;
#(
  parameter int H_ACTIVE    = 640,
  parameter int H_FP        = 16,
  parameter int H_SYNC      = 96,
  parameter int H_BP        = 48,
  parameter int V_ACTIVE    = 480,
  parameter int V_FP        = 10,
  parameter int V_SYNC      = 2,
  parameter int V_BP        = 33,
  parameter int STRIDE_LOG2 = 10,
  parameter int BASE_W      = 11,
  parameter int DATA_W      = 32,
  parameter int REG_AW      = 3,
  parameter int RD_LAT      = 2,
  localparam int WADDR_W    = DATA_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               mem_req,
  output logic [WADDR_W-1:0] mem_addr,
  input  logic               mem_rvalid,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               hsync_n,
  output logic               vsync_n,
  output logic               de,
  output logic [7:0]         red,
  output logic [7:0]         green,
  output logic [7:0]         blue
);
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int H_W     = $clog2(H_TOTAL);
  localparam int V_W     = $clog2(V_TOTAL);

  logic [H_W-1:0]    h_cnt;
  logic [V_W-1:0]    v_cnt;
  logic              vis, hs, vs, frame_apply;
  logic [BASE_W-1:0] act_base;
  ctrl_t             act_ctrl;

  fb_regs #(.REG_AW(REG_AW), .DATA_W(DATA_W), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .apply(frame_apply), .rdata(reg_rdata), .act_base(act_base), .act_ctrl(act_ctrl)
  );

  fb_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk(clk), .rst(rst), .h_cnt(h_cnt), .v_cnt(v_cnt), .vis(vis),
    .hs(hs), .vs(vs), .frame_apply(frame_apply)
  );

  fb_addr_gen #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .H_W(H_W), .V_W(V_W),
    .STRIDE_LOG2(STRIDE_LOG2), .BASE_W(BASE_W), .WADDR_W(WADDR_W)
  ) u_addr (
    .clk(clk), .rst(rst), .h_cnt(h_cnt), .v_cnt(v_cnt), .vis(vis),
    .base(act_base), .ctrl(act_ctrl), .mem_req(mem_req), .mem_addr(mem_addr)
  );

  fb_pixel_out #(.RD_LAT(RD_LAT), .DATA_W(DATA_W)) u_pix (
    .clk(clk), .rst(rst), .vis(vis), .en(act_ctrl.en), .hs(hs), .vs(vs),
    .rvalid(mem_rvalid), .rdata(mem_rdata), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .de(de), .red(red), .green(green), .blue(blue)
  );
endmodule

// File: rtl/fb_scan_ctrl_chk.sv
module fb_scan_ctrl_chk
  import fb_pkg::*;
#(
  parameter int WADDR_W = 30,
  parameter int BASE_W  = 11
) (
  input logic               clk,
  input logic               rst,
  input logic               mem_req,
  input logic [WADDR_W-1:0] mem_addr,
  input logic               hsync_n,
  input logic               vsync_n,
  input logic               de,
  input logic [7:0]         red,
  input logic [7:0]         green,
  input logic [7:0]         blue,
  input ctrl_t              act_ctrl,
  input logic [BASE_W-1:0]  act_base,
  input logic               frame_apply
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!mem_req && hsync_n && vsync_n && !de));

  p_fwd_step_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req) && !act_ctrl.rot) |-> (mem_addr == $past(mem_addr) + 1'b1));

  p_rev_step_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req) && act_ctrl.rot) |-> (mem_addr == $past(mem_addr) - 1'b1));

  p_blank_black_r6: assert property (@(posedge clk) disable iff (rst)
    !de |-> (red == 8'd0 && green == 8'd0 && blue == 8'd0));

  p_no_req_off_r7: assert property (@(posedge clk) disable iff (rst)
    !act_ctrl.en |=> !mem_req);

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act_ctrl) || !$stable(act_base)) |-> $past(frame_apply));
endmodule

bind fb_scan_ctrl fb_scan_ctrl_chk #(.WADDR_W(WADDR_W), .BASE_W(BASE_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .red(red), .green(green),
  .blue(blue), .act_ctrl(act_ctrl), .act_base(act_base), .frame_apply(frame_apply)
);

// File: tb/fb_scan_ctrl_bench.sv
module fb_scan_ctrl_bench;
  localparam int HA = 8, HFP = 2, HS = 3, HBP = 2;
  localparam int VA = 4, VFP = 1, VS = 2, VBP = 1;
  localparam int HT = HA + HFP + HS + HBP;
  localparam int VT = VA + VFP + VS + VBP;
  localparam int LAT = 2;
  localparam int WD = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [29:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        hsync_n, vsync_n, de;
  logic [7:0]  red, green, blue;

  always #5 clk = ~clk;

  fb_scan_ctrl #(
    .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP), .RD_LAT(LAT)
  ) u_fb_scan_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
    .red(red), .green(green), .blue(blue)
  );

  // memory model: fixed latency, content derived from the address
  function automatic logic [31:0] mem_word(input logic [29:0] a);
    return {a[7:0] ^ 8'hC3, a[7:0], a[15:8] ^ 8'h5A, a[19:12] + {4'h0, a[3:0]}};
  endfunction

  logic [1:0]  vp = '0;
  logic [29:0] ap0 = '0, ap1 = '0;
  always @(posedge clk) begin
    vp  <= {vp[0], mem_req};
    ap0 <= mem_addr;
    ap1 <= ap0;
  end
  assign mem_rvalid = vp[1];
  assign mem_rdata  = mem_word(ap1);

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard queues
  logic [29:0] aq[$];
  string       atag[$];
  logic [23:0] pq[$];
  string       ptag[$];

  task automatic push_frame(input bit en, input bit rot, input logic [31:0] base);
    for (int y = 0; y < VA; y++) begin
      for (int x = 0; x < HA; x++) begin
        logic [29:0] a;
        int r, c;
        r = rot ? (VA - 1 - y) : y;
        c = rot ? (HA - 1 - x) : x;
        a = {base[31:21], 19'd0} | 30'(r << 10) | 30'(c);
        if (en) begin
          aq.push_back(a);
          atag.push_back(rot ? "R5" : "R4");
          pq.push_back(mem_word(a)[23:0]);
          ptag.push_back("R6/R8");
        end else begin
          pq.push_back(24'd0);
          ptag.push_back("R7");
        end
      end
    end
  endtask

  // monitors
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req) begin
        if (aq.size() == 0) chk(0, "R4/R7", "unexpected request addr", mem_addr, 0);
        else begin
          logic [29:0] ea;
          string t;
          ea = aq.pop_front();
          t = atag.pop_front();
          chk(mem_addr == ea, t, "request address", mem_addr, ea);
        end
      end
      if (de) begin
        if (pq.size() == 0) chk(0, "R6", "unexpected visible pixel", {red, green, blue}, 0);
        else begin
          logic [23:0] ep;
          string t;
          ep = pq.pop_front();
          t = ptag.pop_front();
          chk({red, green, blue} == ep, t, "pixel rgb", {red, green, blue}, ep);
        end
      end else begin
        chk({red, green, blue} == 24'd0, "R6", "rgb in blanking", {red, green, blue}, 0);
      end
    end
  end

  // sync timing monitor
  bit p_de = 0, p_hs = 1, p_vs = 1, seen_de = 0, seen_hf = 0, seen_vf = 0;
  int t_de = 0, t_hf = 0, t_vf = 0;
  always @(negedge clk) begin
    if (rst) begin
      p_de = de; p_hs = hsync_n; p_vs = vsync_n;
    end else begin
      if (p_de && !de) begin t_de = cyc; seen_de = 1; end
      if (p_hs && !hsync_n) begin
        if (seen_de && (cyc - t_de) < HT)
          chk((cyc - t_de) == HFP, "R2", "hsync after de fall", cyc - t_de, HFP);
        if (seen_hf) chk((cyc - t_hf) == HT, "R2", "line period", cyc - t_hf, HT);
        t_hf = cyc; seen_hf = 1;
      end
      if (!p_hs && hsync_n && seen_hf)
        chk((cyc - t_hf) == HS, "R2", "hsync width", cyc - t_hf, HS);
      if (p_vs && !vsync_n) begin
        if (seen_de)
          chk((cyc - t_de) == (HT - HA + VFP * HT), "R3", "vsync after last pixel",
              cyc - t_de, HT - HA + VFP * HT);
        if (seen_vf) chk((cyc - t_vf) == VT * HT, "R3", "frame period", cyc - t_vf, VT * HT);
        t_vf = cyc; seen_vf = 1;
      end
      if (!p_vs && vsync_n && seen_vf)
        chk((cyc - t_vf) == VS * HT, "R3", "vsync width", cyc - t_vf, VS * HT);
      p_de = de; p_hs = hsync_n; p_vs = vsync_n;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata == exp, tag, "register read", reg_rdata, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    chk(0, "R1..", "watchdog expired cycles", WD, 0);
    summary();
  end

  // stimulus: en, rot, base
  bit          c_en  [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
  bit          c_rot [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
  logic [31:0] c_base[4] = '{32'h0020_0000, 32'hFFF0_1234, 32'h4000_0000, 32'h7FE1_2345};

  initial begin
    push_frame(1'b0, 1'b0, 32'h0);   // frame 0: disabled after reset (R1, R7)
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!mem_req && hsync_n && vsync_n && !de, "R1", "reset outputs idle",
        {mem_req, hsync_n, vsync_n, de}, 4'b0110);
    chk({red, green, blue} == 0 && reg_rdata == 0, "R1", "reset data zero",
        {red, green, blue}, 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      wait (de);
      // mid-frame write: the frame in progress must keep its setting (R8)
      wr(3'd0, c_base[i]);
      wr(3'd4, {16'hABCD, 14'd0, c_rot[i], c_en[i]});
      rd_chk(3'd0, {c_base[i][31:21], 21'd0}, "R9");
      rd_chk(3'd6, {30'd0, c_rot[i], c_en[i]}, "R10");
      @(negedge vsync_n);
      push_frame(c_en[i], c_rot[i], c_base[i]);
    end
    @(negedge vsync_n);
    repeat (10) @(negedge clk);
    chk(aq.size() == 0, "R4", "requests outstanding", aq.size(), 0);
    chk(pq.size() == 0, "R6", "pixels outstanding", pq.size(), 0);
    summary();
  end
endmodule